// File: doc/BRIEF.md
# Multi-Mode Register Load/Store Engine

This block moves one 16-bit word per command between a register file of eight entries and a synchronous single-port data memory. A command carries a direction (load or store), an addressing mode, the data register, a base register, a post-increment flag and a 16-bit constant. The engine forms the operand or the memory address, performs the transfer, and then signals completion.

Five ways of finding the data are offered. The constant can itself be the value, or it can be the address. A register can hold the address, or a register plus the constant can form it. The constant can also point at a memory word that holds the real address. Memory returns read data one cycle after the address is presented. Because of this, the time from a start request to completion depends on the mode: one cycle for an immediate load or a single-address store, three for a single-read load or a pointer-chasing store, and five for a pointer-chasing load. A pointer register can step by one after a register-addressed access, so repeated commands walk an array.

Top module: `amode_xfer`

## Requirements
- R1: Mode code 0 with op=0 (load) writes the constant into register reg_sel. No memory write occurs, and done is high in the first cycle after the accepting edge.
- R2: Mode code 1 uses the constant as the address. A load (op=0) puts the word at that address into reg_sel, with done three cycles after the start cycle. A store (op=1) writes register reg_sel to that address, with done one cycle after start.
- R3: Mode code 2 uses the contents of register base_sel as the memory address, for both load and store.
- R4: Mode code 3 uses register base_sel plus the constant as the address, computed modulo 2^16.
- R5: Mode code 4 first reads the word at the constant address and uses it as a pointer. A load then reads the word at the pointer into reg_sel, with done five cycles after start. A store writes reg_sel to the pointer, with done three cycles after start.
- R6: With post_inc=1 in mode code 2, register base_sel increases by one after its value has been used as the address. In every other mode, post_inc has no effect.
- R7: busy is high from the accepting edge until the completing edge, and it is low while done is high. A start that arrives while busy is high is ignored.
- R8: done is high for exactly one cycle per completed command.
- R9: A store in mode code 0, or any mode code from 5 to 7, raises err for one cycle. In that case done is not raised, memory is not written and no register changes.
- R10: During and right after reset, busy, done, err and mem_we are low, and all registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command request, sampled while idle |
| op | input | 1 | 0 = load into register, 1 = store from register |
| mode | input | 3 | Addressing mode code 0..4 |
| reg_sel | input | 3 | Data register (destination or source) |
| base_sel | input | 3 | Base or pointer register |
| post_inc | input | 1 | Step base register after register-addressed access |
| imm | input | 16 | Constant: value, address or offset |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle illegal-command pulse |
| mem_addr | output | 16 | Memory address (registered) |
| mem_we | output | 1 | Memory write strobe (registered) |
| mem_wdata | output | 16 | Memory write data (registered) |
| mem_rdata | input | 16 | Memory read data, valid one cycle after address |

## Verification
Each addressing mode is exercised by loads over a memory whose words all differ, each holding its own address in its low byte. A wrong address choice, such as base instead of base+offset, or the pointer instead of its target, therefore shows up as a distinct value. An index that overflows 16 bits separates wrapping arithmetic from a widened sum. Consecutive post-incremented loads through the same pointer, followed by an indexed access with the flag set, distinguish stepping in the right mode from stepping in none or in all modes. Stores, the illegal codes and a start issued during a long pointer-chasing load then show whether writes land at the right place, whether rejected commands leave state untouched, and whether a busy engine drops requests.

// File: rtl/amode_pkg.sv
package amode_pkg;
  localparam logic [2:0] M_IMM  = 3'd0;
  localparam logic [2:0] M_DIR  = 3'd1;
  localparam logic [2:0] M_RIND = 3'd2;
  localparam logic [2:0] M_IDX  = 3'd3;
  localparam logic [2:0] M_MIND = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CAPT = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/amode_regfile.sv
module amode_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int RIW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [RIW-1:0] widx,
  input  logic [DW-1:0]  wdata,
  input  logic [RIW-1:0] ra_idx,
  output logic [DW-1:0]  ra_data,
  input  logic [RIW-1:0] rb_idx,
  output logic [DW-1:0]  rb_data
);
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (we && widx == RIW'(g))
        regs[g] <= wdata;
    end
  end

  assign ra_data = regs[ra_idx];
  assign rb_data = regs[rb_idx];
endmodule

// File: rtl/amode_agen.sv
module amode_agen
  import amode_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16
) (
  input  logic [2:0]    mode,
  input  logic [DW-1:0] imm,
  input  logic [DW-1:0] base_val,
  output logic [AW-1:0] ea,
  output logic [DW-1:0] base_next
);
  always_comb begin
    unique case (mode)
      M_RIND:  ea = AW'(base_val);
      M_IDX:   ea = AW'(base_val + imm);
      default: ea = AW'(imm);
    endcase
  end

  assign base_next = base_val + DW'(1);
endmodule

// File: rtl/amode_fsm.sv
module amode_fsm
  import amode_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 16,
  parameter int NREG = 8,
  localparam int RIW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           op,
  input  logic [2:0]     mode,
  input  logic [RIW-1:0] reg_sel,
  input  logic [RIW-1:0] base_sel,
  input  logic           post_inc,
  input  logic [DW-1:0]  imm,
  input  logic [AW-1:0]  ea,
  input  logic [DW-1:0]  src_val,
  input  logic [DW-1:0]  base_next,
  input  logic [DW-1:0]  mem_rdata,
  output logic           rf_we,
  output logic [RIW-1:0] rf_widx,
  output logic [DW-1:0]  rf_wdata,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_we,
  output logic [DW-1:0]  mem_wdata
);
  xfer_state_e    state;
  logic           op_q;
  logic           ind_q;
  logic [RIW-1:0] rsel_q;
  logic [DW-1:0]  sdata_q;
  logic           accept;
  logic           legal;

  assign accept = start && (state == ST_IDLE);
  assign legal  = (mode <= M_MIND) && !(op && mode == M_IMM);
  assign busy   = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      done      <= 1'b0;
      err       <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      op_q      <= 1'b0;
      ind_q     <= 1'b0;
      rsel_q    <= '0;
      sdata_q   <= '0;
    end else begin
      done   <= 1'b0;
      err    <= 1'b0;
      mem_we <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (!legal) begin
              err <= 1'b1;
            end else begin
              op_q    <= op;
              rsel_q  <= reg_sel;
              ind_q   <= (mode == M_MIND);
              sdata_q <= src_val;
              if (mode == M_IMM) begin
                done <= 1'b1;
              end else if (mode == M_MIND) begin
                mem_addr <= AW'(imm);
                state    <= ST_WAIT;
              end else if (op) begin
                mem_addr  <= ea;
                mem_we    <= 1'b1;
                mem_wdata <= src_val;
                done      <= 1'b1;
              end else begin
                mem_addr <= ea;
                state    <= ST_WAIT;
              end
            end
          end
        end
        ST_WAIT: state <= ST_CAPT;
        ST_CAPT: begin
          if (ind_q && op_q) begin
            mem_addr  <= AW'(mem_rdata);
            mem_we    <= 1'b1;
            mem_wdata <= sdata_q;
            done      <= 1'b1;
            state     <= ST_IDLE;
          end else if (ind_q) begin
            mem_addr <= AW'(mem_rdata);
            ind_q    <= 1'b0;
            state    <= ST_WAIT;
          end else begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rf_we    = 1'b0;
    rf_widx  = reg_sel;
    rf_wdata = imm;
    if (accept && legal) begin
      if (mode == M_IMM) begin
        rf_we = 1'b1;
      end else if (mode == M_RIND && post_inc) begin
        rf_we    = 1'b1;
        rf_widx  = base_sel;
        rf_wdata = base_next;
      end
    end
    if (state == ST_CAPT && !ind_q && !op_q) begin
      rf_we    = 1'b1;
      rf_widx  = rsel_q;
      rf_wdata = mem_rdata;
    end
  end
endmodule

// File: rtl/amode_xfer.sv
module amode_xfer #(
  parameter int DW   = 16,
  parameter int AW   = 16,
  parameter int NREG = 8,
  localparam int RIW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           op,
  input  logic [2:0]     mode,
  input  logic [RIW-1:0] reg_sel,
  input  logic [RIW-1:0] base_sel,
  input  logic           post_inc,
  input  logic [DW-1:0]  imm,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_we,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata
);
  logic           rf_we;
  logic [RIW-1:0] rf_widx;
  logic [DW-1:0]  rf_wdata;
  logic [DW-1:0]  src_val;
  logic [DW-1:0]  base_val;
  logic [DW-1:0]  base_next;
  logic [AW-1:0]  ea;

  amode_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst),
    .we(rf_we), .widx(rf_widx), .wdata(rf_wdata),
    .ra_idx(reg_sel), .ra_data(src_val),
    .rb_idx(base_sel), .rb_data(base_val)
  );

  amode_agen #(.DW(DW), .AW(AW)) u_agen (
    .mode(mode), .imm(imm), .base_val(base_val),
    .ea(ea), .base_next(base_next)
  );

  amode_fsm #(.DW(DW), .AW(AW), .NREG(NREG)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .op(op), .mode(mode),
    .reg_sel(reg_sel), .base_sel(base_sel), .post_inc(post_inc), .imm(imm),
    .ea(ea), .src_val(src_val), .base_next(base_next), .mem_rdata(mem_rdata),
    .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata),
    .busy(busy), .done(done), .err(err),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata)
  );
endmodule

// File: rtl/amode_xfer_chk.sv
module amode_xfer_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic err,
  input logic mem_we
);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_err_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    err |-> (!done && !mem_we));

  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> !err);

  p_write_ends_r2: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> done);

  p_reset_quiet_r10: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !done && !err && !mem_we));
endmodule

bind amode_xfer amode_xfer_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy),
  .done(done), .err(err), .mem_we(mem_we)
);

// File: tb/tb_amode_xfer.sv
module tb_amode_xfer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        op = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [2:0]  reg_sel = 3'd0;
  logic [2:0]  base_sel = 3'd0;
  logic        post_inc = 1'b0;
  logic [15:0] imm = 16'd0;
  logic        busy, done, err, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = 16'd0;
  logic [15:0] mem [256];

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  amode_xfer dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .mode(mode),
    .reg_sel(reg_sel), .base_sel(base_sel), .post_inc(post_inc), .imm(imm),
    .busy(busy), .done(done), .err(err),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // bench memory: word i holds A000|i, plus a pointer at 0x40 -> 0x50
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 16'hA000 | 16'(i);
      mem[8'h40] <= 16'h0050;
      mem[8'h50] <= 16'hBEEF;
    end else begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // issue one command; returns cycles until done/err and which ended it
  task automatic run(input bit o, input logic [2:0] m, input logic [2:0] rd,
                     input logic [2:0] rb, input bit pi, input logic [15:0] k,
                     output int lat, output bit saw_err, output bit saw_done);
    @(negedge clk);
    op = o; mode = m; reg_sel = rd; base_sel = rb; post_inc = pi; imm = k;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && !err && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    saw_err = err;
    saw_done = done;
    @(negedge clk);
    check(!done, "R8 done one cycle", done, 0);
  endtask

  // read a register through a direct store to scratch word 0xF0
  task automatic peek(input logic [2:0] r, output logic [15:0] v);
    int l; bit e; bit d;
    run(1'b1, 3'd1, r, 3'd0, 1'b0, 16'h00F0, l, e, d);
    v = mem[8'hF0];
  endtask

  // fields: op(1) mode(3) rd(3) rb(3) pinc(1) imm(16) lat(4) exp(16)
  localparam int NV = 11;
  localparam logic [46:0] VEC [NV] = '{
    {1'b0, 3'd0, 3'd1, 3'd0, 1'b0, 16'h1234, 4'd1, 16'h1234}, // R1
    {1'b0, 3'd1, 3'd2, 3'd0, 1'b0, 16'h0010, 4'd3, 16'hA010}, // R2
    {1'b0, 3'd0, 3'd3, 3'd0, 1'b0, 16'h0020, 4'd1, 16'h0020}, // R1
    {1'b0, 3'd2, 3'd4, 3'd3, 1'b0, 16'h0000, 4'd3, 16'hA020}, // R3
    {1'b0, 3'd3, 3'd5, 3'd3, 1'b0, 16'h0005, 4'd3, 16'hA025}, // R4
    {1'b0, 3'd4, 3'd6, 3'd0, 1'b0, 16'h0040, 4'd5, 16'hBEEF}, // R5
    {1'b0, 3'd0, 3'd7, 3'd0, 1'b0, 16'hFFFF, 4'd1, 16'hFFFF}, // R1
    {1'b0, 3'd3, 3'd0, 3'd7, 1'b0, 16'h0011, 4'd3, 16'hA010}, // R4 wrap
    {1'b0, 3'd2, 3'd1, 3'd3, 1'b1, 16'h0000, 4'd3, 16'hA020}, // R6
    {1'b0, 3'd2, 3'd2, 3'd3, 1'b1, 16'h0000, 4'd3, 16'hA021}, // R6
    {1'b0, 3'd3, 3'd4, 3'd3, 1'b1, 16'h0000, 4'd3, 16'hA022}  // R6 ignored
  };

  initial begin
    int lat; bit e; bit d; int dones; logic [15:0] v;
    repeat (4) @(negedge clk);
    // R10 reset state
    check(!busy && !done && !err && !mem_we, "R10 outputs in reset",
          {busy, done, err, mem_we}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !err && !mem_we, "R10 outputs after reset",
          {busy, done, err, mem_we}, 0);
    peek(3'd5, v);
    check(v == 16'h0000, "R10 register cleared", v, 0);

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][46], VEC[i][45:43], VEC[i][42:40], VEC[i][39:37], VEC[i][36],
          VEC[i][35:20], lat, e, d);
      check(d && !e, "R1-R6 vector done", {d, e}, 2);
      check(lat == int'(VEC[i][19:16]), "R2/R5 vector latency", lat, VEC[i][19:16]);
      peek(VEC[i][42:40], v);
      check(v == VEC[i][15:0], "R1/R3/R4/R5/R6 vector value", v, VEC[i][15:0]);
    end

    // R6: two stepped accesses then indexed access with flag: pointer 0x22
    peek(3'd3, v);
    check(v == 16'h0022, "R6 pointer stepped twice only", v, 16'h0022);

    // R2 direct store
    run(1'b1, 3'd1, 3'd1, 3'd0, 1'b0, 16'h0080, lat, e, d);
    check(lat == 1 && d, "R2 direct store latency", lat, 1);
    check(mem[8'h80] == 16'hA020, "R2 direct store data", mem[8'h80], 16'hA020);
    // R3 register-indirect store via r3=0x22
    run(1'b1, 3'd2, 3'd1, 3'd3, 1'b0, 16'h0000, lat, e, d);
    check(mem[8'h22] == 16'hA020, "R3 indirect store", mem[8'h22], 16'hA020);
    // R4 indexed store: r3 + 0x10 = 0x32
    run(1'b1, 3'd3, 3'd7, 3'd3, 1'b0, 16'h0010, lat, e, d);
    check(mem[8'h32] == 16'hFFFF, "R4 indexed store", mem[8'h32], 16'hFFFF);
    // R5 pointer store: mem[0x40]=0x50
    run(1'b1, 3'd4, 3'd2, 3'd0, 1'b0, 16'h0040, lat, e, d);
    check(lat == 3 && d, "R5 pointer store latency", lat, 3);
    check(mem[8'h50] == 16'hA021, "R5 pointer store data", mem[8'h50], 16'hA021);

    // R9 immediate store rejected
    run(1'b1, 3'd0, 3'd1, 3'd0, 1'b0, 16'h0060, lat, e, d);
    check(e && !d, "R9 immediate store err no done", {e, d}, 2);
    check(mem[8'h60] == 16'hA060, "R9 memory untouched", mem[8'h60], 16'hA060);
    // R9 illegal mode code 5 load into r5
    run(1'b0, 3'd5, 3'd5, 3'd0, 1'b0, 16'h0077, lat, e, d);
    check(e && !d, "R9 mode 5 err", {e, d}, 2);
    peek(3'd5, v);
    check(v == 16'hA025, "R9 register untouched", v, 16'hA025);

    // R7 start during busy ignored
    @(negedge clk);
    op = 1'b0; mode = 3'd4; reg_sel = 3'd0; base_sel = 3'd0; post_inc = 1'b0;
    imm = 16'h0040; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R7 busy after accept", busy, 1);
    dones = done ? 1 : 0;
    @(negedge clk);
    mode = 3'd0; imm = 16'h1111; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dones += done ? 1 : 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (done) begin
        dones++;
        check(!busy, "R7 busy low with done", busy, 0);
      end
      check(!err, "R7 no err while busy", err, 0);
    end
    check(dones == 1, "R7 single completion", dones, 1);
    peek(3'd0, v);
    check(v == 16'hA021, "R7 ignored start left register", v, 16'hA021);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule